// File: doc/BRIEF.md
# Randomized Rotation Element-Selection Encoder

This block sits between the multi-level quantizer of a sigma-delta modulator and an eight-cell unit-element feedback DAC. Each sample it takes a level code and turns on the matching number of cells. Which cells are used changes from sample to sample, so static mismatch between the nominally equal cells becomes broadband noise rather than harmonic tones. Averaged over many samples, each cell carries the same share of the load, and the mean output approaches the ideal level.

The code is first clamped to the cell count and turned into a thermometer vector: code k sets cells 0 to k-1. The vector is then rotated right, with no bits lost, by an amount taken from a 7-bit maximal-length pseudo-random shift register. The register steps once for each accepted sample. The rotated vector is registered and drives the cell enables. A debug input forces the rotation to zero, which gives plain thermometer selection for comparison. The pseudo-random register keeps stepping while this input is set.

Top module: `dem_rotate_encoder`

## Requirements
- R1: A synchronous active-high reset clears the cell-enable word to zero on the next clock edge and loads the pseudo-random register with seed 7'h01.
- R2: With the rotation forced to zero, a valid code k from 0 to 8 produces an enable word in which bits 0 to k-1 are 1 and all other bits are 0 (bit i drives cell i).
- R3: A valid code from 9 to 15 is treated as 8 and enables all eight cells.
- R4: Without the debug override, the enable word is the thermometer vector rotated right by r, so that bit i equals thermometer bit (i + r) mod 8, where r is bits [2:0] of the pseudo-random register at the accepted sample.
- R5: The pseudo-random register is 7 bits wide and steps as next = {s[5:0], s[6] ^ s[5]} (polynomial x^7+x^6+1). It steps once for each clock edge with the valid strobe high, so its sequence repeats after 127 samples.
- R6: While the valid strobe is low, both the enable word and the pseudo-random register hold their values.
- R7: After every valid sample, the number of ones in the enable word equals the clamped code.
- R8: The debug override sets the rotation to zero for that sample only, and the pseudo-random register still steps on that sample.
- R9: The enable word changes on the clock edge that samples a valid code, so it is visible one clock after the code is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| code_vld | input | 1 | Qualifies code_in for this clock |
| code_in | input | 4 | Quantizer level code, 0 to 8 nominal |
| rot_bypass | input | 1 | Forces a rotation of zero for this sample |
| cell_en | output | 8 | Registered enable, one bit per unit cell |

## Verification
Two things can happen on the same edge: a sample is accepted and the pseudo-random register steps. A forced-zero rotation and the register step can also coincide, as can a reset and a valid strobe. The bench drives the override in the middle of runs of rotated samples. It then checks that later rotations continue the sequence as if the override had never been set. It also holds the valid strobe high through a reset and expects the reset to win. A behavioural reference model with its own register is compared against the enable word on every clock. Each accepted sample is also judged by its population count.

// File: rtl/dem_pkg.sv
package dem_pkg;
    localparam int N_CELLS   = 8;
    localparam int CODE_W    = 4;
    localparam int LFSR_W    = 7;
    localparam int ROT_W     = $clog2(N_CELLS);
    localparam logic [LFSR_W-1:0] LFSR_SEED = 7'h01;

    typedef logic [N_CELLS-1:0] cell_vec_t;

    // Clamp a level code to the number of cells.
    function automatic int unsigned clamp_level(input logic [CODE_W-1:0] code);
        if (int'(code) > N_CELLS) return N_CELLS;
        return int'(code);
    endfunction
endpackage

// File: rtl/dem_thermo.sv
module dem_thermo #(
    parameter int N_CELLS = dem_pkg::N_CELLS,
    parameter int CODE_W  = dem_pkg::CODE_W
) (
    input  logic [CODE_W-1:0]  code_i,
    output logic [N_CELLS-1:0] therm_o
);
    localparam int LVL_W = $clog2(N_CELLS + 1);
    localparam int CMP_W = (LVL_W > CODE_W) ? LVL_W : CODE_W;

    logic [CMP_W-1:0] level;

    always_comb begin
        if (CMP_W'(code_i) > CMP_W'(N_CELLS)) level = CMP_W'(N_CELLS);
        else                                  level = CMP_W'(code_i);
    end

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        assign therm_o[i] = (CMP_W'(i) < level);
    end
endmodule

// File: rtl/dem_lfsr.sv
module dem_lfsr #(
    parameter int                LFSR_W = dem_pkg::LFSR_W,
    parameter logic [LFSR_W-1:0] SEED   = dem_pkg::LFSR_SEED
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    output logic [LFSR_W-1:0] state_o
);
    localparam int TAP_HI = LFSR_W - 1;
    localparam int TAP_LO = LFSR_W - 2;

    logic [LFSR_W-1:0] state_q;
    logic              fb;

    assign fb = state_q[TAP_HI] ^ state_q[TAP_LO];

    always_ff @(posedge clk) begin
        if (rst)         state_q <= SEED;
        else if (step_i) state_q <= {state_q[LFSR_W-2:0], fb};
    end

    assign state_o = state_q;
endmodule

// File: rtl/dem_rotator.sv
module dem_rotator #(
    parameter int N_CELLS = dem_pkg::N_CELLS,
    parameter int ROT_W   = dem_pkg::ROT_W
) (
    input  logic [N_CELLS-1:0] vec_i,
    input  logic [ROT_W-1:0]   rot_i,
    output logic [N_CELLS-1:0] vec_o
);
    localparam int IDX_W = $clog2(2 * N_CELLS);

    logic [2*N_CELLS-1:0] doubled;
    assign doubled = {vec_i, vec_i};

    for (genvar i = 0; i < N_CELLS; i++) begin : g_bit
        assign vec_o[i] = doubled[IDX_W'(i) + IDX_W'(rot_i)];
    end
endmodule

// File: rtl/dem_rotate_encoder.sv
module dem_rotate_encoder #(
    parameter int N_CELLS = dem_pkg::N_CELLS,
    parameter int CODE_W  = dem_pkg::CODE_W,
    parameter int LFSR_W  = dem_pkg::LFSR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               code_vld,
    input  logic [CODE_W-1:0]  code_in,
    input  logic               rot_bypass,
    output logic [N_CELLS-1:0] cell_en
);
    localparam int ROT_W = $clog2(N_CELLS);

    logic [N_CELLS-1:0] therm;
    logic [N_CELLS-1:0] rotated;
    logic [LFSR_W-1:0]  pn_state;
    logic [ROT_W-1:0]   rot_amt;
    logic [N_CELLS-1:0] en_q;

    dem_thermo #(.N_CELLS(N_CELLS), .CODE_W(CODE_W)) u_thermo (
        .code_i  (code_in),
        .therm_o (therm)
    );

    dem_lfsr #(.LFSR_W(LFSR_W), .SEED(LFSR_W'(1))) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .step_i  (code_vld),
        .state_o (pn_state)
    );

    assign rot_amt = rot_bypass ? '0 : pn_state[ROT_W-1:0];

    dem_rotator #(.N_CELLS(N_CELLS), .ROT_W(ROT_W)) u_rot (
        .vec_i (therm),
        .rot_i (rot_amt),
        .vec_o (rotated)
    );

    always_ff @(posedge clk) begin
        if (rst)           en_q <= '0;
        else if (code_vld) en_q <= rotated;
    end

    assign cell_en = en_q;
endmodule

// File: rtl/dem_rotate_encoder_chk.sv
module dem_rotate_encoder_chk #(
    parameter int N_CELLS = dem_pkg::N_CELLS,
    parameter int CODE_W  = dem_pkg::CODE_W
) (
    input logic               clk,
    input logic               rst,
    input logic               code_vld,
    input logic [CODE_W-1:0]  code_in,
    input logic               rot_bypass,
    input logic [N_CELLS-1:0] cell_en
);
    // R1: reset clears the enables
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (cell_en == '0));

    // R7: population count tracks the clamped code
    assert_popcount_R7: assert property (@(posedge clk) disable iff (rst)
        code_vld |=> ($countones(cell_en) == dem_pkg::clamp_level($past(code_in))));

    // R6: no valid, no change
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !code_vld |=> $stable(cell_en));

    // R3: over-range codes enable every cell
    assert_saturate_R3: assert property (@(posedge clk) disable iff (rst)
        (code_vld && (int'(code_in) > N_CELLS)) |=> (cell_en == '1));

    // R2, R8: forced zero rotation gives low-side thermometer
    assert_bypass_thermo_R8: assert property (@(posedge clk) disable iff (rst)
        (code_vld && rot_bypass) |=>
            (cell_en == N_CELLS'((1 << dem_pkg::clamp_level($past(code_in))) - 1)));
endmodule

bind dem_rotate_encoder dem_rotate_encoder_chk u_chk (.*);

// File: tb/dem_rotate_encoder_bench.sv
module dem_rotate_encoder_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       code_vld = 1'b0;
    logic [3:0] code_in = 4'd0;
    logic       rot_bypass = 1'b0;
    logic [7:0] cell_en;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    int m_lfsr = 1;
    int m_exp = 0;
    int m_pop = 0;
    bit m_popchk = 1'b0;

    always #2 clk = ~clk;

    dem_rotate_encoder u_dem_rotate_encoder (
        .clk(clk), .rst(rst), .code_vld(code_vld),
        .code_in(code_in), .rot_bypass(rot_bypass), .cell_en(cell_en)
    );

    function automatic int model_clamp(input int c);
        return (c > 8) ? 8 : c;
    endfunction

    function automatic int model_select(input int lvl, input int r);
        int res = 0;
        for (int i = 0; i < 8; i++)
            if (((i + r) % 8) < lvl) res |= (1 << i);
        return res;
    endfunction

    // Behavioural reference, updated on each edge from the driven inputs.
    always @(posedge clk) begin
        if (rst) begin
            m_exp = 0; m_lfsr = 1; m_popchk = 1'b0;
        end else if (code_vld) begin
            int r;
            r = rot_bypass ? 0 : (m_lfsr & 7);
            m_pop = model_clamp(int'(code_in));
            m_exp = model_select(m_pop, r);
            m_lfsr = ((m_lfsr << 1) & 127) | (((m_lfsr >> 6) ^ (m_lfsr >> 5)) & 1);
            m_popchk = 1'b1;
        end else begin
            m_popchk = 1'b0;
        end
    end

    // Compare on every falling edge, away from the active edge.
    always @(negedge clk) begin
        checks++;
        if (int'(cell_en) != m_exp) begin
            errors++;
            $display("FAIL %s (R9 timing): cell_en=%02h expected=%02h", phase, cell_en, m_exp[7:0]);
        end
        if (m_popchk) begin
            checks++;
            if ($countones(cell_en) != m_pop) begin
                errors++;
                $display("FAIL R7: popcount=%0d expected=%0d", $countones(cell_en), m_pop);
            end
        end
    end

    task automatic drive(input bit v, input int c, input bit byp);
        @(negedge clk);
        code_vld = v; code_in = 4'(c); rot_bypass = byp;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R6: watchdog expired, got hang expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        phase = "R1";
        repeat (3) @(negedge clk);
        drive(0, 0, 0);
        rst = 1'b0;
        // R2: every code with forced-zero rotation
        phase = "R2";
        for (int c = 0; c <= 8; c++) drive(1, c, 1);
        // R3: over-range codes saturate
        phase = "R3";
        for (int c = 9; c <= 15; c++) drive(1, c, 1);
        // R5 / R4: single-cell code reveals the rotation sequence, past one period
        phase = "R5";
        for (int k = 0; k < 140; k++) drive(1, 1, 0);
        phase = "R4";
        for (int k = 0; k < 200; k++) drive(1, $urandom_range(0, 15), 0);
        // R6: gaps in the valid strobe hold state
        phase = "R6";
        for (int k = 0; k < 60; k++) drive(k % 3 == 0, $urandom_range(0, 15), 0);
        // R8: override interleaved with rotated samples
        phase = "R8";
        for (int k = 0; k < 80; k++) drive(1, $urandom_range(0, 8), (k % 4) == 1);
        // R1: reset with valid held high
        phase = "R1";
        @(negedge clk); rst = 1'b1; code_vld = 1'b1; code_in = 4'd5;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        phase = "R4";
        for (int k = 0; k < 40; k++) drive(1, $urandom_range(0, 15), 0);
        drive(0, 0, 0);
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule